// File: doc/BRIEF.md
# Low-Rate Software Watchdog

This block watches a slow 1 Hz tick from the system prescaler and raises a system reset request when software stops servicing it. A 2-bit counter moves forward on every tick. Software keeps it from reaching the end by writing a one to the service bit of a 4-bit control word. If a tick arrives while the counter already holds 3, the block raises the reset request. After a service this happens between three and four seconds later. If the tick phase moves because the prescaler was restarted, the margin can shrink to about two seconds.

The control word is read and written over a simple register port. Bit 3 is the write-one service bit and always reads as zero. Bit 2 is a read/write sleep mask bit that other logic may use. Bits 1 and 0 are read-only copies of the two counter stages: bit 1 is the 1/4 Hz stage and bit 0 is the 1/2 Hz stage. A disable input, driven from an option setting elsewhere, stops expiry from reaching the reset output but does not stop the counter. Counting goes on while the system is in standby. A parameter selects the style of the reset request: a one-cycle pulse, or a level held until the system reset is applied.

Top module: `wdg_top`

## Requirements
- R1: After reset, `rd_data` reads 0 and `rst_req` is low.
- R2: Each cycle with `tick_1hz` high and no service write adds one to the count. The count wraps from 3 to 0, and the new value shows in `rd_data[1:0]` in the next cycle.
- R3: A write with `wr_data[3]`=1 clears the count in the next cycle. This takes priority over a tick in the same cycle, and such a tick does not expire.
- R4: A write with `wr_data[3]`=0 leaves the count unchanged, apart from any tick in the same cycle.
- R5: Every write stores `wr_data[2]` as the sleep mask bit, and `rd_data[2]` returns it.
- R6: The values written to bits 1 and 0 have no effect on the count or on `rd_data`.
- R7: `rd_data[3]` always reads 0.
- R8: A tick that is not serviced and arrives with the count at 3 sets `rst_req` high in the next cycle while `wd_off` is low. In pulse mode (HOLD_REQ=0) the request lasts exactly one cycle.
- R9: While `wd_off` is high, an expiring tick does not raise `rst_req`. The count still wraps to 0.
- R10: Ticks advance the count while `standby` is high, exactly as they do when it is low.
- R11: In hold mode (HOLD_REQ=1), once `rst_req` is high it stays high until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_1hz | input | 1 | One-cycle enable from the prescaler, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Write word: [3] service, [2] sleep mask, [1:0] ignored |
| rd_data | output | 4 | Read word: [3] zero, [2] sleep mask, [1] 1/4 Hz stage, [0] 1/2 Hz stage |
| standby | input | 1 | System is in standby; does not stop counting |
| wd_off | input | 1 | Option setting that suppresses the reset request |
| rst_req | output | 1 | System reset request |

## Verification
The assertions assume that `tick_1hz` and `wr_en` are single-cycle strobes sampled on the clock. They also assume that `wd_off` is steady in any cycle where an expiry is judged. Nothing is assumed about how far apart ticks are, so the stimulus issues ticks far more densely than the real one-second rate. This lets all counter values, wraps and expiries occur many times. The random stimulus changes `wd_off` and `standby` only on cycle boundaries, together with the other inputs, and it sometimes places a service write in the same cycle as a tick to exercise the priority rule.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int REG_W   = 4;
  localparam int CNT_W   = 2;
  localparam int SVC_POS = 3;
  localparam int SLP_POS = 2;

  typedef logic [CNT_W-1:0] wcnt_t;
  typedef logic [REG_W-1:0] wreg_t;

  function automatic wcnt_t cnt_step(input wcnt_t c);
    return c + wcnt_t'(1);
  endfunction

  function automatic logic cnt_at_end(input wcnt_t c);
    return &c;
  endfunction

  function automatic wreg_t rd_word(input logic slp, input wcnt_t c);
    wreg_t w;
    w = '0;
    w[SLP_POS] = slp;
    w[CNT_W-1:0] = c;
    return w;
  endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  wreg_t wr_data,
  input  wcnt_t cnt,
  output logic  svc_evt,
  output wreg_t rd_data
);
  logic slp_q;
  // Read-only positions of the write word carry no function.
  logic unused_ro_bits;
  assign unused_ro_bits = ^wr_data[CNT_W-1:0];

  assign svc_evt = wr_en & wr_data[SVC_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slp_q <= 1'b0;
    else if (wr_en) slp_q <= wr_data[SLP_POS];
  end

  assign rd_data = rd_word(slp_q, cnt);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  svc,
  output wcnt_t cnt_q,
  output logic  expire
);
  assign expire = adv & ~svc & cnt_at_end(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (svc) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_step(cnt_q);
  end
endmodule

// File: rtl/wdg_reqgen.sv
module wdg_reqgen #(
  parameter bit HOLD_REQ = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req
);
  generate
    if (HOLD_REQ) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req <= 1'b0;
        else        req <= req | fire;
      end
    end else begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req <= 1'b0;
        else        req <= fire;
      end
    end
  endgenerate
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter bit HOLD_REQ = 1'b0,
  parameter bit STBY_RUN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1hz,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             standby,
  input  logic             wd_off,
  output logic             rst_req
);
  wcnt_t cnt_q;
  logic  svc_evt;
  logic  adv_evt;
  logic  expire_evt;
  logic  fire_evt;

  assign adv_evt  = tick_1hz & (STBY_RUN | ~standby);
  assign fire_evt = expire_evt & ~wd_off;

  wdg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cnt(cnt_q), .svc_evt(svc_evt), .rd_data(rd_data)
  );

  wdg_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv_evt), .svc(svc_evt),
    .cnt_q(cnt_q), .expire(expire_evt)
  );

  wdg_reqgen #(.HOLD_REQ(HOLD_REQ)) u_req (
    .clk(clk), .rst_n(rst_n), .fire(fire_evt), .req(rst_req)
  );
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
  import wdg_pkg::*;
#(
  parameter bit HOLD_REQ = 1'b0,
  parameter bit STBY_RUN = 1'b1
) (
  input logic  clk,
  input logic  rst_n,
  input logic  tick_1hz,
  input logic  standby,
  input logic  wr_en,
  input wreg_t wr_data,
  input wreg_t rd_data,
  input logic  wd_off,
  input logic  rst_req,
  input wcnt_t cnt_q,
  input logic  svc_evt,
  input logic  adv_evt,
  input logic  expire_evt
);
  a_r2_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !svc_evt) |=> cnt_q == cnt_step($past(cnt_q)));

  a_r3_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
    svc_evt |=> cnt_q == '0);

  a_r4_plain_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[SVC_POS] && !tick_1hz) |=> $stable(cnt_q));

  a_r7_service_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[SVC_POS] == 1'b0);

  a_r8_expire_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !wd_off) |=> rst_req);

  a_r8_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!HOLD_REQ && rst_req) |-> $past(expire_evt && !wd_off));

  a_r10_standby_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (STBY_RUN && tick_1hz && standby && !svc_evt) |=> cnt_q == cnt_step($past(cnt_q)));

  a_r11_hold_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD_REQ && rst_req) |=> rst_req);
endmodule

bind wdg_top wdg_chk #(.HOLD_REQ(HOLD_REQ), .STBY_RUN(STBY_RUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .standby(standby),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .wd_off(wd_off),
  .rst_req(rst_req), .cnt_q(cnt_q), .svc_evt(svc_evt), .adv_evt(adv_evt),
  .expire_evt(expire_evt)
);

// File: tb/wdg_top_tb.sv
module wdg_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic       standby = 1'b0;
  logic       wd_off = 1'b0;
  logic [3:0] rd_p, rd_h;
  logic       req_p, req_h;

  int errors = 0;
  int checks = 0;
  logic [1:0] m_cnt;
  logic       m_slp, m_reqp, m_reqh;

  always #10 clk = ~clk;

  wdg_top #(.HOLD_REQ(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_p), .standby(standby),
    .wd_off(wd_off), .rst_req(req_p)
  );

  wdg_top #(.HOLD_REQ(1'b1)) u_dut_hold (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_h), .standby(standby),
    .wd_off(wd_off), .rst_req(req_h)
  );

  function automatic logic [3:0] exp_word(input logic slp, input logic [1:0] c);
    return {1'b0, slp, c[1], c[0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, 32'(rd_p), 32'(exp_word(m_slp, m_cnt)));
    chk(tag, 32'(rd_h), 32'(exp_word(m_slp, m_cnt)));
    chk(tag, 32'(req_p), 32'(m_reqp));
    chk(tag, 32'(req_h), 32'(m_reqh));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_1hz = 0; wr_en = 0; wr_data = 0; standby = 0; wd_off = 0;
    m_cnt = 0; m_slp = 0; m_reqp = 0; m_reqh = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic t, input logic w, input logic [3:0] d,
                      input logic sb, input logic off, input string tag);
    logic svc, fire;
    @(negedge clk);
    tick_1hz = t; wr_en = w; wr_data = d; standby = sb; wd_off = off;
    svc  = w & d[3];
    fire = t & ~svc & (m_cnt == 2'd3) & ~off;
    if (svc)    m_cnt = 2'd0;
    else if (t) m_cnt = m_cnt + 2'd1;
    if (w) m_slp = d[2];
    m_reqp = fire;
    m_reqh = m_reqh | fire;
    @(posedge clk);
    #2;
    check_all(tag);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    #2; check_all("R1 reset state");

    for (int i = 0; i < 3; i++) step(1, 0, 4'h0, 0, 0, "R2 tick count");
    step(1, 0, 4'h0, 0, 0, "R8 expiry request");
    step(0, 0, 4'h0, 0, 0, "R8 pulse one cycle / R11 hold");
    step(0, 0, 4'h0, 0, 0, "R11 hold persists");
    do_reset();
    #2; check_all("R11 cleared by reset");

    step(1, 0, 4'h0, 0, 0, "R2 tick");
    step(1, 0, 4'h0, 0, 0, "R2 tick");
    step(0, 1, 4'h8, 0, 0, "R3 service clears");
    chk("R7 service bit reads zero", 32'(rd_p[3]), 32'd0);
    for (int i = 0; i < 3; i++) step(1, 0, 4'h0, 0, 0, "R2 tick");
    step(1, 1, 4'h8, 0, 0, "R3 service beats tick at 3");
    step(1, 0, 4'h0, 0, 0, "R2 tick");
    step(1, 0, 4'h0, 0, 0, "R2 tick");
    step(0, 1, 4'h0, 0, 0, "R4 plain write keeps count");
    step(0, 1, 4'h4, 0, 0, "R5 sleep mask set");
    step(0, 1, 4'h7, 0, 0, "R6 ro bits ignored");
    step(0, 1, 4'h3, 0, 0, "R6 ro bits ignored, R5 mask cleared");
    step(1, 0, 4'h0, 1, 0, "R10 standby counts");
    step(1, 0, 4'h0, 1, 1, "R9 disabled expiry wraps");
    step(0, 0, 4'h0, 0, 1, "R9 no request");
    for (int i = 0; i < 4; i++) step(1, 0, 4'h0, 1, 0, "R10 standby to expiry");

    do_reset();
    for (int i = 0; i < 2000; i++) begin
      step(1'($urandom % 2), 1'(($urandom % 4) == 0), 4'($urandom),
           1'($urandom % 2), 1'(($urandom % 8) == 0), "R2 random mix");
      if (($urandom % 300) == 0) do_reset();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule